// File: doc/BRIEF.md
# Two-Wire Register Command Slave

This block is the serial front end of a dual-channel register set. It watches an oversampled two-wire bus (clock and data lines, both synchronised to the system clock), finds start and stop conditions, and matches an 8-bit slave address. The first four address bits are a fixed type code and the last four come from strap inputs. After the address it reads an instruction byte. The upper nibble is the opcode. The lower nibble holds a register field and a channel pointer.

Each command becomes a request to a separate register bank. Reads go out at once. Writes and transfers are held until the stop that closes the command. The increment/decrement command keeps stepping the selected wiper, one request per clock pulse, until the next start or stop. The data line is driven only in the open-drain manner. While the bank reports a nonvolatile write in progress, the address is not acknowledged, so a master can poll until the write is done.

Top module: `twcs_slave`

## Requirements
- R1: A start (data falling while clock is high) restarts address reception from any state, including in the middle of a byte. A stop (data rising while clock is high) returns the block to idle.
- R2: The address byte is acknowledged only when it equals `0101` followed by `strap[3:0]`, MSB first. On any other value there is no acknowledge and the block does not respond again until the next start.
- R3: While `busy` is high, a matching address is not acknowledged. Once `busy` is low, the same address is acknowledged.
- R4: Every instruction byte after an acknowledged address is acknowledged, including undefined opcodes. An undefined opcode produces no request, even at the stop that follows.
- R5: Opcode 1001 (read live register, kind 0) and opcode 1011 (read data register, kind 2) pulse a request right after the instruction byte. The slave then sends `00` followed by `rd_data[5:0]`, MSB first, and releases the line for the master's acknowledge.
- R6: Opcode 1010 (write live register, kind 1) and opcode 1100 (write data register, kind 3) acknowledge one data byte and take its low six bits as `req_data`. The request is issued only at the following stop.
- R7: Transfer opcodes 1101 (kind 4), 1110 (kind 5), 0001 (global, kind 6) and 1000 (global, kind 7) take no data byte. Each is issued as one request at the following stop.
- R8: A start that arrives while a write or transfer is pending discards it, and no request is issued for it.
- R9: After opcode 0010 is acknowledged, each complete clock pulse issues one request of kind 8. `req_data[0]` is 1 if data was high during the pulse and 0 if it was low. The request appears after the falling clock edge, so the clock rise that belongs to a stop issues nothing. When pointer bit 1 is set, no step request is issued.
- R10: Instruction bits [1:0] drive `req_ptr`. Instruction bits [3:2] are the register field: field 00, 10, 01 and 11 map to `req_reg` 0, 1, 2 and 3.
- R11: `sda_out` is 1 to release the line and 0 to pull it low. It never changes while the clock is high.
- R12: After reset the line is released and no request is pending or issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_out | output | 1 | Open-drain data control: 0 pulls low, 1 releases |
| strap | input | 4 | Low nibble of the slave address |
| busy | input | 1 | High while the bank performs a nonvolatile write |
| rd_data | input | 6 | Bank read data for the current request fields |
| req_valid | output | 1 | One-cycle request strobe |
| req_kind | output | 4 | Request kind, codes 0 to 8 as listed in R5 to R9 |
| req_ptr | output | 2 | Channel pointer (live register 0/1 or control 0/1) |
| req_reg | output | 2 | Data register index 0 to 3 |
| req_data | output | 6 | Write value, or step direction in bit 0 |

## Verification
Two events can coincide at one bus moment. The clock rise that opens a stop condition is also the sampling rise of a step pulse. A start can likewise land on a command whose commit is still waiting for its stop. The step test ends its pulse train on a low bit and then sends a stop, and it checks that the up and down request counts exactly equal the pulses sent. A separate test sends a transfer, follows it with a repeated start in place of a stop, and checks that the request count does not move.

// File: rtl/twcs_pkg.sv
// Shared types and opcodes of the two-wire register command slave.
// Assumes an 8-bit byte on the bus and 6-bit register payloads.
package twcs_pkg;
    typedef enum logic [3:0] {
        KIND_RD_LIVE   = 4'd0,
        KIND_WR_LIVE   = 4'd1,
        KIND_RD_DR     = 4'd2,
        KIND_WR_DR     = 4'd3,
        KIND_DR2LIVE   = 4'd4,
        KIND_LIVE2DR   = 4'd5,
        KIND_G_DR2LIVE = 4'd6,
        KIND_G_LIVE2DR = 4'd7,
        KIND_STEP      = 4'd8
    } req_kind_t;

    typedef enum logic [2:0] {
        PH_IDLE, PH_ADDR, PH_INSTR, PH_WDATA, PH_RDATA, PH_STEP, PH_WAIT
    } phase_t;

    localparam logic [3:0] OPC_RD_LIVE   = 4'b1001;
    localparam logic [3:0] OPC_WR_LIVE   = 4'b1010;
    localparam logic [3:0] OPC_RD_DR     = 4'b1011;
    localparam logic [3:0] OPC_WR_DR     = 4'b1100;
    localparam logic [3:0] OPC_DR2LIVE   = 4'b1101;
    localparam logic [3:0] OPC_LIVE2DR   = 4'b1110;
    localparam logic [3:0] OPC_G_DR2LIVE = 4'b0001;
    localparam logic [3:0] OPC_G_LIVE2DR = 4'b1000;
    localparam logic [3:0] OPC_STEP      = 4'b0010;
endpackage

// File: rtl/twcs_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous inputs.
// Assumes the inputs idle at RST_VAL (bus lines idle high).
module twcs_sync #(
    parameter int            STAGES  = 2,
    parameter int            WIDTH   = 2,
    parameter logic          RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Shift each bit one flop deeper per clock.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= {WIDTH{RST_VAL}};
                else if (s == 0) stg[s] <= d;
                else stg[s] <= stg[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/twcs_cond.sv
// Bus event detector: clock edges, start and stop from synchronised lines.
// Assumes clk oversamples the bus clock by several cycles per phase.
module twcs_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_p, sda_p;

    // Hold the previous sample of both lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl;
            sda_p <= sda;
        end
    end

    assign scl_rise  = scl & ~scl_p;
    assign scl_fall  = ~scl & scl_p;
    assign start_det = scl & scl_p & sda_p & ~sda;
    assign stop_det  = scl & scl_p & ~sda_p & sda;
endmodule

// File: rtl/twcs_decode.sv
// Opcode classifier: maps the instruction nibble to a request kind and
// the byte sequence that follows it. Purely combinational.
module twcs_decode
    import twcs_pkg::*;
(
    input  logic [3:0] opcode,
    output req_kind_t  kind,
    output logic       known,
    output logic       is_read,
    output logic       is_write,
    output logic       is_step
);
    // Classify the opcode.
    always_comb begin
        kind     = KIND_RD_LIVE;
        known    = 1'b1;
        is_read  = 1'b0;
        is_write = 1'b0;
        is_step  = 1'b0;
        case (opcode)
            OPC_RD_LIVE:   begin kind = KIND_RD_LIVE;   is_read  = 1'b1; end
            OPC_RD_DR:     begin kind = KIND_RD_DR;     is_read  = 1'b1; end
            OPC_WR_LIVE:   begin kind = KIND_WR_LIVE;   is_write = 1'b1; end
            OPC_WR_DR:     begin kind = KIND_WR_DR;     is_write = 1'b1; end
            OPC_DR2LIVE:   kind = KIND_DR2LIVE;
            OPC_LIVE2DR:   kind = KIND_LIVE2DR;
            OPC_G_DR2LIVE: kind = KIND_G_DR2LIVE;
            OPC_G_LIVE2DR: kind = KIND_G_LIVE2DR;
            OPC_STEP:      begin kind = KIND_STEP;      is_step  = 1'b1; end
            default:       known = 1'b0;
        endcase
    end
endmodule

// File: rtl/twcs_slave.sv
// Two-wire register command slave. Parses address, instruction and data
// bytes, acknowledges on an open-drain line, and issues one-cycle requests
// to an external register bank. Assumes the bank answers rd_data
// combinationally from req_ptr/req_reg and raises busy during NV writes.
module twcs_slave
    import twcs_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter int         BYTE_W      = 8,
    parameter int         DATA_W      = 6,
    parameter int         STRAP_W     = 4,
    parameter logic [3:0] TYPE_ID     = 4'b0101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_out,
    input  logic [STRAP_W-1:0] strap,
    input  logic              busy,
    input  logic [DATA_W-1:0] rd_data,
    output logic              req_valid,
    output logic [3:0]        req_kind,
    output logic [1:0]        req_ptr,
    output logic [1:0]        req_reg,
    output logic [DATA_W-1:0] req_data
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam int PAD_W = BYTE_W - DATA_W;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    logic scl_s, sda_s;
    logic scl_rise, scl_fall, start_det, stop_det;
    req_kind_t dec_kind;
    logic dec_known, dec_read, dec_write, dec_step;

    phase_t             phase, nxt_phase;
    logic [CNT_W-1:0]   cnt;
    logic [BYTE_W-1:0]  shreg, tx;
    logic               ack_slot, drv_low, pend, step_dir;
    req_kind_t          cmd_kind, req_kind_q;
    logic [1:0]         cmd_ptr, cmd_reg;
    logic [DATA_W-1:0]  cmd_data;
    logic [BYTE_W-1:0]  tx_load;

    twcs_sync #(.STAGES(SYNC_STAGES), .WIDTH(2), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q({scl_s, sda_s}));

    twcs_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl(scl_s), .sda(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det));

    twcs_decode u_dec (
        .opcode(shreg[BYTE_W-1 -: 4]), .kind(dec_kind), .known(dec_known),
        .is_read(dec_read), .is_write(dec_write), .is_step(dec_step));

    assign tx_load  = {{PAD_W{1'b0}}, rd_data};
    assign sda_out  = ~drv_low;
    assign req_kind = req_kind_q;

    // Bus protocol sequencer: bit counting, acknowledge, read shifting,
    // step pulses and commit of pending commands at stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            nxt_phase  <= PH_IDLE;
            cnt        <= '0;
            shreg      <= '0;
            tx         <= '0;
            ack_slot   <= 1'b0;
            drv_low    <= 1'b0;
            pend       <= 1'b0;
            step_dir   <= 1'b0;
            cmd_kind   <= KIND_RD_LIVE;
            cmd_ptr    <= '0;
            cmd_reg    <= '0;
            cmd_data   <= '0;
            req_valid  <= 1'b0;
            req_kind_q <= KIND_RD_LIVE;
            req_ptr    <= '0;
            req_reg    <= '0;
            req_data   <= '0;
        end else begin
            req_valid <= 1'b0;
            if (start_det) begin
                phase    <= PH_ADDR;
                cnt      <= '0;
                ack_slot <= 1'b0;
                drv_low  <= 1'b0;
                pend     <= 1'b0;
            end else if (stop_det) begin
                if (pend) begin
                    req_valid  <= 1'b1;
                    req_kind_q <= cmd_kind;
                    req_ptr    <= cmd_ptr;
                    req_reg    <= cmd_reg;
                    req_data   <= cmd_data;
                end
                phase    <= PH_IDLE;
                ack_slot <= 1'b0;
                drv_low  <= 1'b0;
                pend     <= 1'b0;
            end else if (scl_rise) begin
                if (phase == PH_STEP)
                    step_dir <= sda_s;
                else if (cnt != FULL && !ack_slot &&
                         (phase == PH_ADDR || phase == PH_INSTR || phase == PH_WDATA)) begin
                    shreg <= {shreg[BYTE_W-2:0], sda_s};
                    cnt   <= cnt + 1'b1;
                end else if (phase == PH_RDATA && cnt != FULL)
                    cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
                if (ack_slot) begin
                    ack_slot <= 1'b0;
                    cnt      <= '0;
                    phase    <= nxt_phase;
                    if (nxt_phase == PH_RDATA) begin
                        tx      <= tx_load;
                        drv_low <= ~tx_load[BYTE_W-1];
                    end else
                        drv_low <= 1'b0;
                end else if (phase == PH_RDATA) begin
                    if (cnt != FULL) begin
                        tx      <= {tx[BYTE_W-2:0], 1'b0};
                        drv_low <= ~tx[BYTE_W-2];
                    end else begin
                        drv_low <= 1'b0;
                        phase   <= PH_WAIT;
                    end
                end else if (phase == PH_STEP) begin
                    if (!cmd_ptr[1]) begin
                        req_valid  <= 1'b1;
                        req_kind_q <= KIND_STEP;
                        req_ptr    <= cmd_ptr;
                        req_reg    <= cmd_reg;
                        req_data   <= {{(DATA_W-1){1'b0}}, step_dir};
                    end
                end else if (cnt == FULL) begin
                    case (phase)
                        PH_ADDR: begin
                            if (shreg == {TYPE_ID, strap} && !busy) begin
                                drv_low   <= 1'b1;
                                ack_slot  <= 1'b1;
                                nxt_phase <= PH_INSTR;
                            end else
                                phase <= PH_IDLE;
                        end
                        PH_INSTR: begin
                            drv_low  <= 1'b1;
                            ack_slot <= 1'b1;
                            cmd_kind <= dec_kind;
                            cmd_ptr  <= shreg[1:0];
                            cmd_reg  <= {shreg[2], shreg[3]};
                            if (!dec_known)
                                nxt_phase <= PH_WAIT;
                            else if (dec_read) begin
                                req_valid  <= 1'b1;
                                req_kind_q <= dec_kind;
                                req_ptr    <= shreg[1:0];
                                req_reg    <= {shreg[2], shreg[3]};
                                nxt_phase  <= PH_RDATA;
                            end else if (dec_write)
                                nxt_phase <= PH_WDATA;
                            else if (dec_step)
                                nxt_phase <= PH_STEP;
                            else begin
                                pend      <= 1'b1;
                                nxt_phase <= PH_WAIT;
                            end
                        end
                        PH_WDATA: begin
                            drv_low   <= 1'b1;
                            ack_slot  <= 1'b1;
                            cmd_data  <= shreg[DATA_W-1:0];
                            pend      <= 1'b1;
                            nxt_phase <= PH_WAIT;
                        end
                        default: phase <= PH_WAIT;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/twcs_slave_chk.sv
// Property checker for twcs_slave, attached by bind below.
module twcs_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [3:0] req_kind,
    input logic [1:0] req_ptr,
    input logic       sda_out,
    input logic       scl_s,
    input logic       start_det,
    input logic       stop_det,
    input logic       in_idle
);
    // Requests are single-cycle strobes.
    assert_req_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    // Writes and transfers (kinds 1,3..7) only follow a stop.
    assert_commit_at_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_kind == 4'd1 || (req_kind >= 4'd3 && req_kind <= 4'd7)))
        |-> $past(stop_det));

    // Step requests only for pointer values 00 and 01.
    assert_step_ptr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 4'd8) |-> !req_ptr[1]);

    // Data line changes only while the clock is low.
    assert_sda_low_phase_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_out) && !$past(start_det) && !$past(stop_det)) |-> !scl_s);

    // Idle slave never pulls the line.
    assert_idle_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
        in_idle |-> sda_out);
endmodule

bind twcs_slave twcs_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_ptr(req_ptr), .sda_out(sda_out), .scl_s(scl_s),
    .start_det(start_det), .stop_det(stop_det),
    .in_idle(phase == twcs_pkg::PH_IDLE));

// File: tb/sim_twcs_slave.sv
module sim_twcs_slave;
    localparam int Q = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1, busy = 1'b0;
    logic [3:0] strap = 4'b1010;
    logic       sda_out, req_valid;
    logic [3:0] req_kind;
    logic [1:0] req_ptr, req_reg;
    logic [5:0] req_data, rd_data;
    wire        sda_bus = sda_m & sda_out;

    int checks = 0, errors = 0, n_req = 0, n_up = 0, n_dn = 0, sda_viol = 0;
    logic [3:0] l_kind = '0;
    logic [1:0] l_ptr = '0, l_reg = '0;
    logic [5:0] l_data = '0;
    logic       sda_prev = 1'b1;

    always #4 clk = ~clk;

    // Bank model: read value is a function of the request fields.
    assign rd_data = {req_ptr, 2'b10, req_reg};

    twcs_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
        .sda_out(sda_out), .strap(strap), .busy(busy), .rd_data(rd_data),
        .req_valid(req_valid), .req_kind(req_kind), .req_ptr(req_ptr),
        .req_reg(req_reg), .req_data(req_data));

    always @(negedge clk) begin
        if (rst_n && req_valid) begin
            n_req++;
            l_kind = req_kind; l_ptr = req_ptr; l_reg = req_reg; l_data = req_data;
            if (req_kind == 4'd8) begin
                if (req_data[0]) n_up++; else n_dn++;
            end
        end
        if (rst_n && sda_out != sda_prev && scl_m) sda_viol++;
        sda_prev = sda_out;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        b = sda_bus; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic put_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic get_byte(output logic [7:0] v, input logic mack);
        logic b;
        for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
        put_bit(~mack);
    endtask

    function automatic logic [7:0] addr_ok();
        return {4'b0101, strap};
    endfunction

    task automatic t_reset();
        check(sda_out == 1'b1, "R12 released", sda_out, 1);
        check(req_valid == 1'b0 && n_req == 0, "R12 no request", n_req, 0);
    endtask

    task automatic t_address();
        logic ack;
        int n0 = n_req;
        bus_start(); put_byte(addr_ok(), ack); bus_stop();
        check(ack == 1'b1, "R2 match ack", ack, 1);
        bus_start(); put_byte({4'b0101, ~strap}, ack);
        check(ack == 1'b0, "R2 strap mismatch", ack, 0);
        put_byte(8'h92, ack);
        check(ack == 1'b0, "R2 silent after mismatch", ack, 0);
        bus_stop();
        bus_start(); put_byte({4'b0110, strap}, ack); bus_stop();
        check(ack == 1'b0, "R2 type mismatch", ack, 0);
        // R1: start in the middle of a byte restarts address reception
        bus_start(); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        bus_start(); put_byte(addr_ok(), ack); bus_stop();
        check(ack == 1'b1, "R1 restart mid byte", ack, 1);
        check(n_req == n0, "R1 no stray request", n_req, n0);
    endtask

    task automatic t_busy();
        logic ack;
        busy = 1'b1;
        bus_start(); put_byte(addr_ok(), ack); bus_stop();
        check(ack == 1'b0, "R3 busy withholds ack", ack, 0);
        busy = 1'b0;
        bus_start(); put_byte(addr_ok(), ack); bus_stop();
        check(ack == 1'b1, "R3 ack after busy", ack, 1);
    endtask

    task automatic t_read(input logic [3:0] opc, input logic [1:0] rf, input logic [1:0] ptr,
                          input int kind, input int ridx);
        logic ack; logic [7:0] v;
        logic [7:0] exp = {2'b00, ptr, 2'b10, ridx[1:0]};
        int n0 = n_req;
        bus_start(); put_byte(addr_ok(), ack);
        put_byte({opc, rf, ptr}, ack);
        check(ack == 1'b1, "R4 instruction ack", ack, 1);
        get_byte(v, 1'b0); bus_stop();
        check(v == exp, "R5 read byte", v, exp);
        check(n_req == n0 + 1 && l_kind == 4'(kind), "R5 read request kind", l_kind, kind);
        check(l_ptr == ptr && l_reg == ridx[1:0], "R10 read fields", {l_ptr, l_reg}, {ptr, ridx[1:0]});
    endtask

    task automatic t_write(input logic [3:0] opc, input logic [1:0] rf, input logic [1:0] ptr,
                           input logic [7:0] d, input int kind, input int ridx);
        logic ack;
        int n0 = n_req;
        bus_start(); put_byte(addr_ok(), ack);
        put_byte({opc, rf, ptr}, ack);
        put_byte(d, ack);
        check(ack == 1'b1, "R6 data ack", ack, 1);
        check(n_req == n0, "R6 held until stop", n_req, n0);
        bus_stop();
        check(n_req == n0 + 1 && l_kind == 4'(kind), "R6 commit kind", l_kind, kind);
        check(l_data == d[5:0], "R6 data value", l_data, d[5:0]);
        check(l_ptr == ptr && l_reg == ridx[1:0], "R10 write fields", {l_ptr, l_reg}, {ptr, ridx[1:0]});
    endtask

    task automatic t_xfer(input logic [3:0] opc, input logic [1:0] rf, input logic [1:0] ptr,
                          input int kind, input int ridx);
        logic ack;
        int n0 = n_req;
        bus_start(); put_byte(addr_ok(), ack);
        put_byte({opc, rf, ptr}, ack);
        check(n_req == n0, "R7 held until stop", n_req, n0);
        bus_stop();
        check(n_req == n0 + 1 && l_kind == 4'(kind), "R7 transfer kind", l_kind, kind);
        check(l_reg == ridx[1:0], "R10 transfer register", l_reg, ridx);
    endtask

    task automatic t_abort();
        logic ack;
        int n0 = n_req;
        bus_start(); put_byte(addr_ok(), ack); put_byte(8'b1101_1100, ack);
        bus_start(); put_byte({4'b0101, ~strap}, ack); bus_stop();
        check(n_req == n0, "R8 transfer aborted by start", n_req, n0);
        bus_start(); put_byte(addr_ok(), ack); put_byte(8'b1100_0001, ack);
        put_byte(8'h15, ack);
        bus_start(); put_byte(addr_ok(), ack); bus_stop();
        check(n_req == n0, "R8 write aborted by start", n_req, n0);
    endtask

    task automatic t_undef();
        logic ack;
        int n0 = n_req;
        bus_start(); put_byte(addr_ok(), ack); put_byte(8'b0100_0000, ack);
        check(ack == 1'b1, "R4 undefined opcode acked", ack, 1);
        bus_stop();
        check(n_req == n0, "R4 undefined opcode ignored", n_req, n0);
    endtask

    task automatic t_step();
        logic ack;
        int n0 = n_req, u0c = n_up, d0c = n_dn;
        bus_start(); put_byte(addr_ok(), ack); put_byte(8'b0010_0001, ack);
        check(ack == 1'b1, "R9 step instruction ack", ack, 1);
        put_bit(1'b1); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
        bus_stop();
        check(n_up - u0c == 3, "R9 up steps", n_up - u0c, 3);
        check(n_dn - d0c == 2, "R9 down steps, stop adds none", n_dn - d0c, 2);
        check(n_req - n0 == 5 && l_ptr == 2'b01, "R9 step count and pointer", n_req - n0, 5);
        n0 = n_req;
        bus_start(); put_byte(addr_ok(), ack); put_byte(8'b0010_0010, ack);
        put_bit(1'b1); put_bit(1'b0);
        bus_stop();
        check(n_req == n0, "R9 pointer 10 steps ignored", n_req, n0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        tick(4); rst_n = 1'b1; tick(4);
        t_reset();
        t_address();
        t_busy();
        t_read(4'b1001, 2'b00, 2'b10, 0, 0);
        t_read(4'b1011, 2'b10, 2'b01, 2, 1);
        t_write(4'b1010, 2'b00, 2'b01, 8'h2D, 1, 0);
        t_write(4'b1100, 2'b01, 2'b11, 8'h33, 3, 2);
        t_xfer(4'b1101, 2'b11, 2'b00, 4, 3);
        t_xfer(4'b1110, 2'b10, 2'b01, 5, 1);
        t_xfer(4'b0001, 2'b01, 2'b00, 6, 2);
        t_xfer(4'b1000, 2'b00, 2'b00, 7, 0);
        t_abort();
        t_undef();
        t_step();
        check(sda_viol == 0, "R11 line changes only with clock low", sda_viol, 0);
        finish_run();
    end
endmodule